// File: doc/BRIEF.md
# Strobe Switch Decoder

The block drives the six gate enables of a time-sequential RGB LED driver. A two-bit color code picks one of three colors or the dark state. A layout bit picks between two LED package wirings: a common-anode package, and a package with two cathodes and one anode. Each color code also picks which of three 10-bit current-DAC words goes to the current regulator. A flag marks when that word is in force.

Each time the wanted switch pattern changes, the block first opens every switch that the new pattern does not need. Switches that are closed and stay closed are never opened. The switches the new pattern adds close only after a programmable dead time. That dead time is counted in ticks of TICK_CYCLES clocks, about 111 ns each, and lasts (dead_code + 2) ticks. A new code that arrives during a dead time opens the switches toward the newest pattern and starts the count again. Pulling enable low is treated as a change to a pattern with all switches open.

Top module: `strobe_switch_decoder`

## Requirements
- R1: During and right after a synchronous active-low reset, sw_close is 0, dac_valid is 0 and dac_word is 0.
- R2: With map_cca = 0, the settled sw_close (bit i = switch i+1) is 0x07 for code 0, 0x0F for code 1, 0x17 for code 2 and 0x27 for code 3.
- R3: With map_cca = 1, the settled sw_close is 0x00 for code 0, 0x21 for code 1, 0x1C for code 2 and 0x1A for code 3.
- R4: When settled, codes 1, 2 and 3 give dac_valid = 1 and dac_word = dac_a, dac_b and dac_c. Code 0, and every cycle of a dead time, gives dac_valid = 0 and dac_word = 0.
- R5: One clock edge after the inputs ask for a different pattern, sw_close becomes the previous sw_close ANDed with the new pattern.
- R6: A switch that is closed in both the old and the new pattern stays closed through the whole transition.
- R7: The switches the new pattern adds close exactly (dead_code + 2) * TICK_CYCLES clock edges after the opening edge, and not earlier.
- R8: A different pattern asked for during a dead time opens the switches to the current sw_close ANDed with the newest pattern, and the full dead time restarts from that edge.
- R9: With enable low, all switches open one edge later and dac_valid is 0. Changes of color code or layout while enable is low have no effect. Raising enable starts a normal transition.
- R10: dead_code is captured when a transition starts. Changing it during the dead time does not change that transition's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Strobe enable; low forces all switches open |
| color_sel | input | 2 | Color code: 0 dark, 1..3 select channel A..C |
| map_cca | input | 1 | Package layout: 0 common anode, 1 cathode-cathode-anode |
| dead_code | input | BBM_W | Dead-time code; dead time is (dead_code+2) ticks |
| dac_a | input | DAC_W | Current word for code 1 |
| dac_b | input | DAC_W | Current word for code 2 |
| dac_c | input | DAC_W | Current word for code 3 |
| sw_close | output | 6 | Switch gate enables, bit i closes switch i+1 |
| dac_word | output | DAC_W | Current word in force, 0 when not valid |
| dac_valid | output | 1 | A color's current word is in force |

## Verification
A wrong stored target pattern shows up as a wrong settled sw_close or dac_word once the dead time ends. That is at most (dead_code + 2) * TICK_CYCLES edges after a change. A wrong opening mask shows up on the very first edge after a change. A dead-time counter that is off by one, or that holds the wrong captured code, moves the closing edge. The bench therefore checks sw_close on the last cycle before the expected close and again on the cycle after it. Every ordered pair of codes is swept for both layouts, so a switch that is dropped or added in any pattern appears directly at the ports.

// File: rtl/strobe_pkg.sv
// Shared types and the switch-pattern table for the strobe decoder.
// Assumes six switches and a two-bit color code; bit i of a mask is switch i+1.
package strobe_pkg;

    localparam int NUM_SW = 6;
    localparam int CODE_W = 2;

    typedef logic [NUM_SW-1:0] sw_mask_t;
    typedef logic [CODE_W-1:0] color_code_t;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_DEAD = 1'b1
    } seq_state_e;

    // Switch pattern for a color code under one of the two package layouts.
    function automatic sw_mask_t pattern_of(input color_code_t code, input logic cca);
        sw_mask_t m;
        m = '0;
        if (!cca) begin
            // Common anode: low three always closed, one cathode switch per color.
            m[2:0] = 3'b111;
            if (code != '0) m[2 + int'(code)] = 1'b1;
        end else begin
            case (code)
                2'd1:    m = 6'b100001;
                2'd2:    m = 6'b011100;
                2'd3:    m = 6'b011010;
                default: m = 6'b000000;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/sw_pattern_map.sv
// Turns enable, color code and layout bit into the wanted switch pattern
// and the effective code (0 when disabled). Purely combinational.
module sw_pattern_map
    import strobe_pkg::*;
(
    input  logic        enable,
    input  color_code_t color_sel,
    input  logic        map_cca,
    output color_code_t code_eff,
    output sw_mask_t    want_mask
);

    // Gate the code with enable, then look up the pattern.
    always_comb begin
        code_eff  = enable ? color_sel : '0;
        want_mask = enable ? pattern_of(color_sel, map_cca) : '0;
    end

endmodule

// File: rtl/bbm_timer.sv
// Dead-time timer. A start pulse captures the dead-time code and restarts
// the count. fire pulses on the edge that ends (code+2) ticks of TICK_CYCLES
// clocks, counted from the start edge. Assumes TICK_CYCLES >= 1.
module bbm_timer #(
    parameter int TICK_CYCLES = 14,
    parameter int BBM_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BBM_W-1:0] dead_code,
    output logic             fire
);

    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int TK_W  = BBM_W + 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

    logic             running;
    logic [PRE_W-1:0] pre;
    logic [TK_W-1:0]  tk;
    logic [TK_W-1:0]  lim;
    logic             tick;

    // Tick strobe from the prescaler.
    always_comb begin
        tick = running && (pre == PRE_LAST);
        fire = tick && (tk == lim) && !start;
    end

    // Prescaler, tick counter and captured limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pre     <= '0;
            tk      <= '0;
            lim     <= '0;
        end else if (start) begin
            running <= 1'b1;
            pre     <= '0;
            tk      <= '0;
            lim     <= TK_W'(dead_code) + TK_W'(1);
        end else if (running) begin
            if (tick) begin
                pre <= '0;
                if (tk == lim) running <= 1'b0;
                else           tk      <= tk + TK_W'(1);
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end

    // R7: the tick count never passes the captured limit.
    p_tick_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (tk <= lim));

    // R10: the captured limit holds while the count runs without a restart.
    p_limit_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && !$past(start) && running) |-> $stable(lim));

endmodule

// File: rtl/dac_route.sv
// Picks the current word of the active color code. The word is zeroed and
// the valid flag dropped for code 0 or while the sequencer is not settled.
module dac_route
    import strobe_pkg::*;
#(
    parameter int DAC_W = 10
) (
    input  color_code_t      code,
    input  logic             settled,
    input  logic [DAC_W-1:0] dac_a,
    input  logic [DAC_W-1:0] dac_b,
    input  logic [DAC_W-1:0] dac_c,
    output logic [DAC_W-1:0] dac_word,
    output logic             dac_valid
);

    logic [DAC_W-1:0] chan [4];

    assign chan[0] = '0;
    assign chan[1] = dac_a;
    assign chan[2] = dac_b;
    assign chan[3] = dac_c;

    // Select the channel and gate it with the valid condition.
    always_comb begin
        dac_valid = settled && (code != '0);
        dac_word  = dac_valid ? chan[code] : '0;
    end

endmodule

// File: rtl/strobe_switch_decoder.sv
// Break-before-make strobe decoder. It holds the target pattern, opens
// unneeded switches one edge after a change, and closes new ones when the
// dead timer fires. Assumes the inputs are synchronous to clk.
module strobe_switch_decoder
    import strobe_pkg::*;
#(
    parameter int TICK_CYCLES = 14,
    parameter int BBM_W       = 8,
    parameter int DAC_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       color_sel,
    input  logic             map_cca,
    input  logic [BBM_W-1:0] dead_code,
    input  logic [DAC_W-1:0] dac_a,
    input  logic [DAC_W-1:0] dac_b,
    input  logic [DAC_W-1:0] dac_c,
    output logic [5:0]       sw_close,
    output logic [DAC_W-1:0] dac_word,
    output logic             dac_valid
);

    color_code_t code_eff;
    sw_mask_t    want_mask;
    color_code_t goal_code;
    sw_mask_t    goal_mask;
    sw_mask_t    sw_q;
    seq_state_e  st;
    logic        chg;
    logic        fire;

    sw_pattern_map u_map (
        .enable    (enable),
        .color_sel (color_sel),
        .map_cca   (map_cca),
        .code_eff  (code_eff),
        .want_mask (want_mask)
    );

    bbm_timer #(.TICK_CYCLES(TICK_CYCLES), .BBM_W(BBM_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (chg),
        .dead_code (dead_code),
        .fire      (fire)
    );

    dac_route #(.DAC_W(DAC_W)) u_dac (
        .code      (goal_code),
        .settled   (st == ST_HOLD),
        .dac_a     (dac_a),
        .dac_b     (dac_b),
        .dac_c     (dac_c),
        .dac_word  (dac_word),
        .dac_valid (dac_valid)
    );

    // Detect a request for a different code or pattern.
    always_comb chg = {code_eff, want_mask} != {goal_code, goal_mask};

    // Target capture, opening on change, closing when the dead time ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            goal_code <= '0;
            goal_mask <= '0;
            sw_q      <= '0;
            st        <= ST_HOLD;
        end else if (chg) begin
            goal_code <= code_eff;
            goal_mask <= want_mask;
            sw_q      <= sw_q & want_mask;
            st        <= ST_DEAD;
        end else if (st == ST_DEAD && fire) begin
            sw_q <= goal_mask;
            st   <= ST_HOLD;
        end
    end

    assign sw_close = sw_q;

    // R7: a switch closes only on the edge where the dead timer fires.
    p_close_on_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_close & ~$past(sw_close))) |-> $past(fire));

    // R6: switches closed before a change and still wanted stay closed.
    p_keep_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chg) |-> ((sw_close & $past(sw_close & want_mask)) == $past(sw_close & want_mask)));

    // R4: a valid current word implies some switch is closed.
    p_valid_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> (sw_close != '0));

    // R9: with enable low nothing closes and the word is not valid.
    p_enable_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!dac_valid && ((sw_close & ~$past(sw_close)) == '0)));

endmodule

// File: tb/strobe_switch_decoder_test.sv
// Sweep bench for the strobe decoder with a short tick.
module strobe_switch_decoder_test;

    localparam int T  = 2;
    localparam int BW = 8;
    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [1:0]    color_sel = '0;
    logic          map_cca = 1'b0;
    logic [BW-1:0] dead_code = '0;
    logic [DW-1:0] dac_a = 10'h155;
    logic [DW-1:0] dac_b = 10'h2AA;
    logic [DW-1:0] dac_c = 10'h3FF;
    logic [5:0]    sw_close;
    logic [DW-1:0] dac_word;
    logic          dac_valid;

    int checks = 0;
    int fails  = 0;
    logic [5:0] cur_sw = '0;
    int         cur_d  = 0;
    logic [1:0] cur_code = '0;

    strobe_switch_decoder #(.TICK_CYCLES(T), .BBM_W(BW), .DAC_W(DW)) uut (
        .clk, .rst_n, .enable, .color_sel, .map_cca, .dead_code,
        .dac_a, .dac_b, .dac_c, .sw_close, .dac_word, .dac_valid
    );

    always #4 clk = ~clk;

    function automatic logic [5:0] exp_mask(input logic en, input logic m, input logic [1:0] c);
        logic [5:0] r;
        if (!en) return 6'h00;
        if (!m) r = (c == 2'd0) ? 6'h07 : (6'h07 | (6'h01 << (c + 2)));
        else begin
            case (c)
                2'd1: r = 6'h21;
                2'd2: r = 6'h1C;
                2'd3: r = 6'h1A;
                default: r = 6'h00;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive a new request at a negedge and check the opening edge (R5, R6, R8).
    task automatic start_change(input logic en, input logic m, input logic [1:0] c, input int bbm);
        logic [5:0] nm;
        nm = exp_mask(en, m, c);
        enable = en; map_cca = m; color_sel = c; dead_code = BW'(bbm);
        @(negedge clk);
        check("R5 open mask", sw_close, cur_sw & nm);
        check("R6 kept closed", sw_close & cur_sw & nm, cur_sw & nm);
        check("R4 invalid in dead time", dac_valid, 0);
        cur_sw   = cur_sw & nm;
        cur_d    = (bbm + 2) * T;
        cur_code = en ? c : 2'd0;
    endtask

    // Wait out the dead time and check the closing edge (R2, R3, R4, R7).
    task automatic finish_change(input logic en, input logic m, input logic [1:0] c);
        logic [5:0] nm;
        int expw;
        nm = exp_mask(en, m, c);
        repeat (cur_d - 1) @(negedge clk);
        check("R7 not yet closed", sw_close, cur_sw);
        @(negedge clk);
        check(m ? "R3 settled mask" : "R2 settled mask", sw_close, nm);
        expw = (cur_code == 2'd1) ? int'(dac_a) : (cur_code == 2'd2) ? int'(dac_b) :
               (cur_code == 2'd3) ? int'(dac_c) : 0;
        check("R4 dac valid", dac_valid, (cur_code != 0) ? 1 : 0);
        check("R4 dac word", dac_word, expw);
        cur_sw = nm;
    endtask

    task automatic transition(input logic en, input logic m, input logic [1:0] c, input int bbm);
        start_change(en, m, c, bbm);
        finish_change(en, m, c);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset sw", sw_close, 0);
        check("R1 reset valid", dac_valid, 0);
        check("R1 reset word", dac_word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", sw_close, 0);

        // Sweep every ordered pair of codes under both layouts (R2, R3, R4, R5, R6, R7).
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    if (a != b) begin
                        if (exp_mask(1'b1, m[0], a[1:0]) != cur_sw || cur_code != a[1:0] || !enable)
                            transition(1'b1, m[0], a[1:0], 0);
                        transition(1'b1, m[0], b[1:0], (a + b) % 4);
                    end
                end
            end
        end

        // Longest dead time (R7).
        transition(1'b1, 1'b0, 2'd1, 0);
        transition(1'b1, 1'b0, 2'd3, 255);

        // Restart during dead time (R8).
        transition(1'b1, 1'b0, 2'd1, 0);
        start_change(1'b1, 1'b0, 2'd2, 2);
        repeat (3) @(negedge clk);
        check("R8 still open", sw_close, cur_sw);
        start_change(1'b1, 1'b0, 2'd3, 2);
        finish_change(1'b1, 1'b0, 2'd3);

        // Dead-time code captured at start (R10).
        transition(1'b1, 1'b1, 2'd2, 0);
        start_change(1'b1, 1'b1, 2'd3, 4);
        dead_code = '0;
        finish_change(1'b1, 1'b1, 2'd3);

        // Enable low (R9).
        transition(1'b1, 1'b0, 2'd3, 1);
        transition(1'b0, 1'b0, 2'd3, 1);
        color_sel = 2'd1; map_cca = 1'b1;
        repeat (10) @(negedge clk);
        check("R9 ignored while disabled", sw_close, 0);
        check("R9 valid low", dac_valid, 0);
        transition(1'b1, 1'b1, 2'd1, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule